// File: doc/BRIEF.md
# SPI Serial SRAM Slave with Hold

This block is the serial front end of an 8,192-byte memory. A host on an SPI bus selects the device with an active-low select line. It then sends a command byte and a two-byte address, and continues with any number of data bytes. A write command stores each completed byte into the memory. A read command streams bytes out on the serial output. The address steps after every byte, so a single frame can cover a whole burst. Both idle clock polarities are accepted: clock idling low with sampling on the rising edge (mode 0), and clock idling high with the same edges (mode 3).

The serial pins are brought into the system clock domain through a synchronizer, and clock edges are detected there. The memory side is a synchronous single-port interface: a one-cycle write strobe, and a read strobe whose data comes back on the next cycle. An active-low pause input stops a transfer in the middle of a frame without deselecting the device. A ready input from the power controller suspends all serial traffic while supply is unsafe. The serial output is a data bit plus an output enable. The enable low means the pin floats.

Top module: `spi_sram_slave`

## Requirements
- R1: After reset, so_oe, mem_we and mem_re are all 0.
- R2: Command byte 0x02, followed by a 16-bit address sent high byte first, starts a write. Of the address, only the low 13 bits are kept. Every completed data byte, received MSB first on si at rising sck edges, produces exactly one single-cycle mem_we pulse with that byte at the current address. mem_we and mem_re are never high together.
- R3: Command byte 0x03 followed by the 16-bit address starts a read. Data is driven on so MSB first. Each bit is updated after a falling sck edge and is valid at the next rising edge, in both mode 0 and mode 3. so_oe is high only during the read data phase.
- R4: After each data byte, the address increments. It wraps from 0x1FFF to 0x0000, for both reads and writes within one frame.
- R5: While cs_n is high, so_oe is 0, and sck and si cause no memory access.
- R6: A rising cs_n in the middle of a byte ends the frame. The partial byte is not written, and the next frame starts again with a command byte.
- R7: While hold_n is low, sck edges are ignored, the bit position is kept, and so_oe is 0. After hold_n returns high, the transfer continues at the same bit.
- R8: While pwr_ok is low, sck edges are ignored, so_oe is 0 and no memory access occurs. Once pwr_ok is high again, normal frames work.
- R9: A command byte other than 0x02 or 0x03 makes the rest of the frame ignored. No memory access occurs and so_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial pins are sampled with it |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Power controller ready; low suspends serial traffic |
| cs_n | input | 1 | Active-low device select |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data into the block |
| hold_n | input | 1 | Active-low pause of the current transfer |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so; 0 means high impedance |
| mem_addr | output | 13 | Memory byte address |
| mem_we | output | 1 | Single-cycle write strobe |
| mem_re | output | 1 | Read strobe; data expected on mem_rdata next cycle |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read from memory |

## Verification
The bench goes after the following corner cases:
- **Address wrap at the top of memory.** A burst is started at 0x1FFE in both directions. A design that failed to wrap would write past the array or return the wrong third byte.
- **Ignored upper address bits.** An address with its top three bits set is used. If those bits leaked into the address, the byte would land somewhere else.
- **Mid-byte deselect.** A frame is cut off five bits into a data byte. A design that kept partial bytes would corrupt the next location, and one that kept its framing would misread the following command.
- **Pause.** hold_n is pulsed inside an address byte and inside a read data byte while sck keeps toggling. A design that counted those edges would shift the address, or drop or repeat output bits.
- **Ignored traffic.** Full frames are sent with the device deselected, with the device not ready, and with an unknown command. Any memory strobe or output enable in those windows is reported.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_RD = 8'h03;
  localparam logic [BYTE_W-1:0] CMD_WR = 8'h02;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADR,
    ST_WR,
    ST_RD,
    ST_SKIP
  } frame_st_e;
endpackage

// File: rtl/spi_sram_pin_sync.sv
module spi_sram_pin_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= RST_VAL;
        else        chain_q <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/spi_sram_frame.sv
module spi_sram_frame
  import spi_sram_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              rise,
  input  logic              si_s,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              in_read,
  output logic [2:0]        bit_idx,
  output logic [BYTE_W-1:0] rd_buf
);
  localparam int ADR_BYTES = (ADDR_W + BYTE_W - 1) / BYTE_W;
  localparam int IDX_W     = (ADR_BYTES > 1) ? $clog2(ADR_BYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ADR_BYTES - 1);

  frame_st_e         st_q, st_n;
  logic [2:0]        bit_q, bit_n;
  logic [6:0]        sh_q, sh_n;
  logic [ADDR_W-1:0] adr_q, adr_n, maddr_q, maddr_n, adr_full;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              rd_q, rd_n, we_q, we_n, re_q, re_n, re_d_q;
  logic [BYTE_W-1:0] wdat_q, wdat_n, buf_q, buf_n, byte_in;

  assign byte_in  = {sh_q, si_s};
  assign adr_full = ADDR_W'({adr_q, byte_in});

  always_comb begin
    st_n = st_q; bit_n = bit_q; sh_n = sh_q; adr_n = adr_q; idx_n = idx_q;
    rd_n = rd_q; maddr_n = maddr_q; wdat_n = wdat_q;
    we_n = 1'b0; re_n = 1'b0;
    buf_n = re_d_q ? rd_data : buf_q;
    if (cs_s) begin
      st_n = ST_CMD; bit_n = '0; idx_n = '0;
    end else if (rise) begin
      sh_n  = byte_in[6:0];
      bit_n = bit_q + 3'd1;
      if (bit_q == 3'd7) begin
        unique case (st_q)
          ST_CMD: begin
            idx_n = '0;
            if (byte_in == CMD_RD)      begin rd_n = 1'b1; st_n = ST_ADR; end
            else if (byte_in == CMD_WR) begin rd_n = 1'b0; st_n = ST_ADR; end
            else                        st_n = ST_SKIP;
          end
          ST_ADR: begin
            adr_n = adr_full;
            if (idx_q == IDX_LAST) begin
              if (rd_q) begin
                re_n = 1'b1; maddr_n = adr_full;
                adr_n = adr_full + ADDR_W'(1); st_n = ST_RD;
              end else begin
                st_n = ST_WR;
              end
            end else begin
              idx_n = idx_q + IDX_W'(1);
            end
          end
          ST_WR: begin
            we_n = 1'b1; maddr_n = adr_q; wdat_n = byte_in;
            adr_n = adr_q + ADDR_W'(1);
          end
          ST_RD: begin
            re_n = 1'b1; maddr_n = adr_q;
            adr_n = adr_q + ADDR_W'(1);
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_CMD; bit_q <= '0; sh_q <= '0; adr_q <= '0; idx_q <= '0;
      rd_q <= 1'b0; maddr_q <= '0; wdat_q <= '0; we_q <= 1'b0;
      re_q <= 1'b0; re_d_q <= 1'b0; buf_q <= '0;
    end else begin
      st_q <= st_n; bit_q <= bit_n; sh_q <= sh_n; adr_q <= adr_n; idx_q <= idx_n;
      rd_q <= rd_n; maddr_q <= maddr_n; wdat_q <= wdat_n; we_q <= we_n;
      re_q <= re_n; re_d_q <= re_q; buf_q <= buf_n;
    end
  end

  assign mem_addr  = maddr_q;
  assign mem_we    = we_q;
  assign mem_re    = re_q;
  assign mem_wdata = wdat_q;
  assign in_read   = (st_q == ST_RD);
  assign bit_idx   = bit_q;
  assign rd_buf    = buf_q;

  // R2
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) we_q |=> !we_q);
  // R2
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(we_q && re_q));
  // R9
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SKIP) |-> (!we_q && !re_q));
endmodule

// File: rtl/spi_sram_so_drive.sv
module spi_sram_so_drive
  import spi_sram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              active,
  input  logic              cs_s,
  input  logic              in_read,
  input  logic [2:0]        bit_idx,
  input  logic [BYTE_W-1:0] rd_buf,
  output logic              so,
  output logic              so_oe
);
  logic so_q, so_n, live_q, live_n;

  always_comb begin
    so_n = so_q; live_n = live_q;
    if (cs_s) begin
      live_n = 1'b0;
    end else if (fall && in_read) begin
      so_n   = rd_buf[~bit_idx];
      live_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_q <= 1'b0; live_q <= 1'b0;
    end else begin
      so_q <= so_n; live_q <= live_n;
    end
  end

  assign so    = so_q;
  assign so_oe = live_q & active;

  // R5
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_s |=> !live_q);
endmodule

// File: rtl/spi_sram_slave.sv
module spi_sram_slave
  import spi_sram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              hold_n,
  output logic              so,
  output logic              so_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);
  logic cs_s, sck_s, si_s, hold_s, sck_d;
  logic active, rise, fall, in_read;
  logic [2:0]        bit_idx;
  logic [BYTE_W-1:0] rd_buf;

  spi_sram_pin_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, sck, si, hold_n}),
    .q({cs_s, sck_s, si_s, hold_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign active = !cs_s && hold_s && pwr_ok;
  assign rise   = active && sck_s && !sck_d;
  assign fall   = active && !sck_s && sck_d;

  spi_sram_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .rise(rise), .si_s(si_s),
    .rd_data(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .in_read(in_read), .bit_idx(bit_idx), .rd_buf(rd_buf)
  );

  spi_sram_so_drive u_so (
    .clk(clk), .rst_n(rst_n), .fall(fall), .active(active), .cs_s(cs_s),
    .in_read(in_read), .bit_idx(bit_idx), .rd_buf(rd_buf), .so(so), .so_oe(so_oe)
  );

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_s && !cs_s) |=> $stable(bit_idx));
  // R3
  so_phase_chk: assert property (@(posedge clk) disable iff (!rst_n) so_oe |-> in_read);
  // R8
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (!mem_we && !mem_re));
endmodule

// File: tb/tb_spi_sram_slave.sv
module tb_spi_sram_slave;
  localparam int HP = 6;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, pwr_ok, cs_n, sck, si, hold_n, so, so_oe, mem_we, mem_re;
  logic [12:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  spi_sram_slave dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0] mem [int];
  int wr_cnt = 0, rd_cnt = 0, we_run = 0, we_long = 0;
  bit oe_seen = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (mem_we) begin mem[int'(mem_addr)] = mem_wdata; wr_cnt++; end
    if (mem_re) begin
      mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'hEE;
      rd_cnt++;
    end
    if (mem_we) we_run++; else we_run = 0;
    if (we_run > 1) we_long++;
    if (so_oe) oe_seen = 1;
  end

  function automatic logic [7:0] mget(int a);
    return mem.exists(a) ? mem[a] : 8'hEE;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_begin(input bit m3);
    sck = m3; wt(HP); cs_n = 1'b0; wt(HP);
  endtask

  task automatic frame_end(input bit m3);
    sck = m3; wt(HP); cs_n = 1'b1; wt(3 * HP);
  endtask

  task automatic spi_bit(input logic b, output logic sov, output logic oev);
    sck = 1'b0; si = b; wt(HP);
    sov = so; oev = so_oe;
    sck = 1'b1; wt(HP);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, output bit oe_all);
    logic s, o;
    oe_all = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      spi_bit(tx[i], s, o);
      rx[i] = s;
      if (!o) oe_all = 1'b0;
    end
  endtask

  logic [7:0] txb [8];
  logic [7:0] rxb [8];
  bit         oeb [8];

  task automatic xfer(input bit m3, input logic [7:0] op, input logic [15:0] a, input int n);
    logic [7:0] dr; bit dob;
    frame_begin(m3);
    spi_byte(op, dr, dob);
    spi_byte(a[15:8], dr, dob);
    spi_byte(a[7:0], dr, dob);
    for (int k = 0; k < n; k++) spi_byte(txb[k], rxb[k], oeb[k]);
    frame_end(m3);
  endtask

  // {mode3, address, data}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 16'h0000, 8'h5A}, {1'b1, 16'h1FFF, 8'hC3}, {1'b0, 16'hE123, 8'h81},
    {1'b1, 16'h0A55, 8'h00}, {1'b0, 16'h1000, 8'hFF}, {1'b1, 16'h7ABC, 8'h3C}
  };

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int w0, r0;
    logic [7:0] dr, rx;
    logic s, o;
    bit dob, oe_ok;
    rst_n = 1'b0; pwr_ok = 1'b1; cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1;
    wt(5);
    chk(!so_oe && !mem_we && !mem_re, "R1 in reset", {so_oe, mem_we, mem_re}, 0);
    rst_n = 1'b1; wt(5);
    chk(!so_oe && !mem_we && !mem_re, "R1 after reset", {so_oe, mem_we, mem_re}, 0);

    // R2 / R3: table of single-byte write then read-back in the other mode
    foreach (VEC[v]) begin
      w0 = wr_cnt;
      txb[0] = VEC[v][7:0];
      xfer(VEC[v][24], 8'h02, VEC[v][23:8], 1);
      chk(wr_cnt == w0 + 1, "R2 write count", wr_cnt - w0, 1);
      chk(mget(int'(VEC[v][20:8])) == VEC[v][7:0], "R2 stored byte",
          mget(int'(VEC[v][20:8])), VEC[v][7:0]);
      txb[0] = 8'h00;
      xfer(!VEC[v][24], 8'h03, VEC[v][23:8], 1);
      chk(rxb[0] == VEC[v][7:0], "R3 read data", rxb[0], VEC[v][7:0]);
      chk(oeb[0], "R3 so_oe in data phase", oeb[0], 1);
    end

    // R4: burst across the top of memory
    txb[0] = 8'h11; txb[1] = 8'h22; txb[2] = 8'h33;
    xfer(1'b0, 8'h02, 16'h1FFE, 3);
    chk(mget(32'h1FFE) == 8'h11, "R4 burst wr 0", mget(32'h1FFE), 8'h11);
    chk(mget(32'h1FFF) == 8'h22, "R4 burst wr 1", mget(32'h1FFF), 8'h22);
    chk(mget(32'h0000) == 8'h33, "R4 burst wr wrap", mget(32'h0000), 8'h33);
    xfer(1'b1, 8'h03, 16'h1FFE, 3);
    chk(rxb[0] == 8'h11 && rxb[1] == 8'h22 && rxb[2] == 8'h33, "R4 burst rd",
        {rxb[0], rxb[1], rxb[2]}, 24'h112233);
    chk(we_long == 0, "R2 write strobe single cycle", we_long, 0);

    // R5: traffic while deselected
    w0 = wr_cnt; r0 = rd_cnt; oe_seen = 0;
    for (int i = 0; i < 24; i++) spi_bit(i[0] ^ i[2], s, o);
    sck = 1'b0; wt(3 * HP);
    chk(wr_cnt == w0 && rd_cnt == r0, "R5 no access deselected", wr_cnt + rd_cnt, w0 + r0);
    chk(!oe_seen, "R5 so_oe deselected", oe_seen, 0);

    // R6: abort in the middle of the second data byte
    mem[32'h41] = 8'h99; w0 = wr_cnt;
    frame_begin(1'b0);
    spi_byte(8'h02, dr, dob); spi_byte(8'h00, dr, dob); spi_byte(8'h40, dr, dob);
    spi_byte(8'h11, dr, dob);
    for (int i = 7; i >= 3; i--) spi_bit(1'b1, s, o);
    cs_n = 1'b1; wt(3 * HP); sck = 1'b0; wt(HP);
    chk(wr_cnt == w0 + 1, "R6 only full byte written", wr_cnt - w0, 1);
    chk(mget(32'h41) == 8'h99, "R6 partial byte dropped", mget(32'h41), 8'h99);
    xfer(1'b0, 8'h03, 16'h0040, 2);
    chk(rxb[0] == 8'h11 && rxb[1] == 8'h99, "R6 fresh frame after abort",
        {rxb[0], rxb[1]}, 16'h1199);

    // R7: pause inside the low address byte of a write
    w0 = wr_cnt;
    frame_begin(1'b0);
    spi_byte(8'h02, dr, dob); spi_byte(8'h00, dr, dob);
    for (int i = 7; i >= 4; i--) spi_bit(logic'(8'h87 >> i), s, o);
    sck = 1'b0; wt(HP); hold_n = 1'b0; wt(HP);
    for (int i = 0; i < 3; i++) begin si = ~si; sck = 1'b1; wt(HP); sck = 1'b0; wt(HP); end
    hold_n = 1'b1; wt(HP);
    for (int i = 3; i >= 0; i--) spi_bit(logic'(8'h87 >> i), s, o);
    spi_byte(8'hB7, dr, dob);
    frame_end(1'b0);
    chk(mget(32'h87) == 8'hB7 && wr_cnt == w0 + 1, "R7 write resumes same bit",
        mget(32'h87), 8'hB7);

    // R7: pause inside a read data byte (mode 3)
    frame_begin(1'b1);
    spi_byte(8'h03, dr, dob); spi_byte(8'h00, dr, dob); spi_byte(8'h87, dr, dob);
    oe_ok = 1'b1;
    for (int i = 7; i >= 5; i--) begin spi_bit(1'b0, s, o); rx[i] = s; if (!o) oe_ok = 0; end
    sck = 1'b0; wt(HP); hold_n = 1'b0; wt(HP);
    chk(!so_oe, "R7 so floats on hold", so_oe, 0);
    for (int i = 0; i < 2; i++) begin sck = 1'b1; wt(HP); sck = 1'b0; wt(HP); end
    hold_n = 1'b1; wt(HP);
    for (int i = 4; i >= 0; i--) begin spi_bit(1'b0, s, o); rx[i] = s; if (!o) oe_ok = 0; end
    frame_end(1'b1);
    chk(rx == 8'hB7, "R7 read resumes same bit", rx, 8'hB7);
    chk(oe_ok, "R7 so_oe back after hold", oe_ok, 1);

    // R8: not ready
    pwr_ok = 1'b0; wt(2);
    w0 = wr_cnt; r0 = rd_cnt; oe_seen = 0;
    txb[0] = 8'h77;
    xfer(1'b0, 8'h02, 16'h0200, 1);
    xfer(1'b0, 8'h03, 16'h0087, 1);
    chk(wr_cnt == w0 && rd_cnt == r0, "R8 no access when not ready", wr_cnt + rd_cnt, w0 + r0);
    chk(!oe_seen, "R8 so_oe when not ready", oe_seen, 0);
    chk(!mem.exists(32'h200), "R8 location untouched", mem.exists(32'h200), 0);
    pwr_ok = 1'b1; wt(2);
    xfer(1'b0, 8'h03, 16'h0087, 1);
    chk(rxb[0] == 8'hB7, "R8 recovery read", rxb[0], 8'hB7);

    // R9: unknown command
    w0 = wr_cnt; r0 = rd_cnt; oe_seen = 0;
    txb[0] = 8'h44; txb[1] = 8'h45;
    xfer(1'b0, 8'h05, 16'h0087, 2);
    chk(wr_cnt == w0 && rd_cnt == r0, "R9 no access on unknown cmd", wr_cnt + rd_cnt, w0 + r0);
    chk(!oe_seen && mget(32'h87) == 8'hB7, "R9 no output, data kept", mget(32'h87), 8'hB7);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule